// File: doc/BRIEF.md
# Two-Wide In-Order Issue Stage

This block sits between instruction fetch and the functional units of a two-way in-order superscalar core. It keeps a window of two decoded instructions: a head place for the older one and a second place for the one behind it. In every cycle it decides whether to send none, the head alone, or both of them to their functional units. Program order is never broken. When the head can go but the second cannot, the head is sent and the second moves up into the head place, ready for the next cycle.

The head goes when its unit is free. The second instruction goes only if the head goes in the same cycle, it needs a different unit, that unit is free, and it has no register conflict with the head. A unit counts as occupied when it raises its external busy line, or while its issue-interval timer is still running. That timer makes slow units, such as a divider, accept at most one operation per interval. Fetch refills the places through a two-lane valid/ready handshake. Each issue slot comes out registered, together with a per-unit strobe.

Top module: `dual_issue_dispatch`

## Requirements
- R1: Right after reset both issue slots, all unit strobes and the stall flag are low, and both fetch lanes report ready.
- R2: Every accepted instruction is issued exactly once, in acceptance order. Slot 0 comes before slot 1 within a cycle. With the default widths the instruction word has these fields: bits [1:0] unit, [6:2] source A, [11:7] source B, [16:12] destination, [24:17] tag.
- R3: Slot 1 is never valid unless slot 0 is valid in the same cycle.
- R4: At most one operation goes to any unit per cycle. The unit strobe vector has exactly the bits of the units named by the valid slots.
- R5: The pair is not sent together when either source of the second instruction equals the head's destination and that destination is nonzero. A zero destination never blocks the pair.
- R6: The pair is not sent together when both instructions name the same nonzero destination.
- R7: Successive issues to unit u are at least II(u) cycles apart, with II = 1, 1, 2, 3 for units 0 to 3 by default. A waiting instruction goes in the first cycle its interval allows.
- R8: No instruction goes to a unit whose busy input was high in the cycle the decision was made.
- R9: When only the head issues, the second instruction moves to the head place and may issue in the very next cycle.
- R10: When the head place is filled and nothing issues, the stall flag is high in the next cycle. While both places stay occupied, neither fetch lane is ready.
- R11: Lane 0 is ready when at least one place is free after this cycle's issue. Lane 1 is ready only when both places are free. Empty places never issue.
- R12: With no conflict, both instructions issue in the same cycle. Issue appears on the outputs one clock after the decision.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 2 | Fetch lane valids; bit 0 is the older lane |
| in_instr0_i | input | 25 | Instruction on fetch lane 0 |
| in_instr1_i | input | 25 | Instruction on fetch lane 1 |
| in_ready_o | output | 2 | Fetch lane readies |
| unit_busy_i | input | 4 | External busy line of each functional unit |
| iss0_valid_o | output | 1 | Older issue slot valid |
| iss0_instr_o | output | 25 | Instruction in older issue slot |
| iss1_valid_o | output | 1 | Younger issue slot valid |
| iss1_instr_o | output | 25 | Instruction in younger issue slot |
| unit_go_o | output | 4 | Per-unit issue strobes |
| stall_o | output | 1 | Head held with nothing issued last cycle |

## Verification
The assertions assume that fetch never raises lane 1 without lane 0, and that unit fields name existing units. The stimulus always sets lane 1 together with lane 0, and it draws unit numbers only below the unit count. Register numbers come from a small range, so read-after-write and same-destination pairs are common. A low zero-destination rate is also covered by a directed case. Busy lines switch at random at a low rate, so the interval timers and the external busy lines overlap.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    ISSUE_NONE  = 2'd0,
    ISSUE_OLDER = 2'd1,
    ISSUE_PAIR  = 2'd2
  } issue_e;
endpackage

// File: rtl/disp_window.sv
module disp_window
  import disp_pkg::*;
#(
  parameter int IW = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  issue_e        issue_sel,
  input  logic [1:0]    in_valid_i,
  input  logic [IW-1:0] in_instr0_i,
  input  logic [IW-1:0] in_instr1_i,
  output logic [1:0]    in_ready_o,
  output logic          head_valid_o,
  output logic [IW-1:0] head_instr_o,
  output logic          next_valid_o,
  output logic [IW-1:0] next_instr_o
);
  logic          head_v_q, next_v_q;
  logic [IW-1:0] head_q, next_q;
  logic          keep0_v, keep1_v;
  logic [IW-1:0] keep0, keep1;
  logic          acc0, acc1;

  // places left over after this cycle's issue, oldest first
  always_comb begin
    keep0_v = 1'b0; keep0 = head_q;
    keep1_v = 1'b0; keep1 = next_q;
    case (issue_sel)
      ISSUE_NONE: begin
        keep0_v = head_v_q; keep1_v = next_v_q;
      end
      ISSUE_OLDER: begin
        keep0_v = next_v_q; keep0 = next_q;
      end
      default: ;
    endcase
  end

  assign in_ready_o = {!keep0_v, !keep1_v};
  assign acc0 = in_valid_i[0] && in_ready_o[0];
  assign acc1 = in_valid_i[0] && in_valid_i[1] && in_ready_o[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v_q <= 1'b0;
      next_v_q <= 1'b0;
      head_q   <= '0;
      next_q   <= '0;
    end else if (!keep0_v) begin
      head_v_q <= acc0;
      head_q   <= in_instr0_i;
      next_v_q <= acc1;
      next_q   <= in_instr1_i;
    end else if (!keep1_v) begin
      head_v_q <= 1'b1;
      head_q   <= keep0;
      next_v_q <= acc0;
      next_q   <= in_instr0_i;
    end else begin
      head_v_q <= 1'b1;
      head_q   <= keep0;
      next_v_q <= 1'b1;
      next_q   <= keep1;
    end
  end

  assign head_valid_o = head_v_q;
  assign head_instr_o = head_q;
  assign next_valid_o = next_v_q;
  assign next_instr_o = next_q;

  AST_WINDOW_PACKED: assert property (@(posedge clk) disable iff (rst)
    next_v_q |-> head_v_q);  // R11
  AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (issue_sel != ISSUE_NONE) |-> head_v_q);  // R11
  AST_PAIR_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    (issue_sel == ISSUE_PAIR) |-> next_v_q);  // R11
  AST_FULL_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (head_v_q && next_v_q && issue_sel == ISSUE_NONE) |-> (in_ready_o == 2'b00));  // R10
endmodule

// File: rtl/disp_interval.sv
module disp_interval #(
  parameter int II   = 1,
  parameter int CW   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic ext_busy_i,
  output logic busy_o
);
  localparam logic [CW-1:0] RELOAD = CW'(II - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (go_i)          cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = ext_busy_i || (cnt_q != '0);

  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    go_i |-> (cnt_q == '0 && !ext_busy_i));  // R8
  AST_INTERVAL_GAP: assert property (@(posedge clk) disable iff (rst)
    (go_i && II > 1) |=> !go_i);  // R7
endmodule

// File: rtl/disp_select.sv
module disp_select #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int REG_W     = 5
) (
  input  logic                 head_v,
  input  logic [UNIT_W-1:0]    head_unit,
  input  logic [REG_W-1:0]     head_dst,
  input  logic                 next_v,
  input  logic [UNIT_W-1:0]    next_unit,
  input  logic [REG_W-1:0]     next_srca,
  input  logic [REG_W-1:0]     next_srcb,
  input  logic [REG_W-1:0]     next_dst,
  input  logic [NUM_UNITS-1:0] unit_busy,
  output logic                 take_head,
  output logic                 take_next
);
  logic head_writes, raw_hit, waw_hit, same_unit;

  always_comb begin
    head_writes = (head_dst != '0);
    raw_hit     = head_writes && ((next_srca == head_dst) || (next_srcb == head_dst));
    waw_hit     = head_writes && (next_dst == head_dst);
    same_unit   = (next_unit == head_unit);
    take_head   = head_v && !unit_busy[head_unit];
    take_next   = take_head && next_v && !unit_busy[next_unit]
                  && !same_unit && !raw_hit && !waw_hit;
  end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import disp_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int REG_W     = 5,
  parameter int TAG_W     = 8,
  parameter int II_W      = 3,
  parameter logic [NUM_UNITS*II_W-1:0] UNIT_II = {3'd3, 3'd2, 3'd1, 3'd1},
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int IW       = UNIT_W + 3*REG_W + TAG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           in_valid_i,
  input  logic [IW-1:0]        in_instr0_i,
  input  logic [IW-1:0]        in_instr1_i,
  output logic [1:0]           in_ready_o,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  output logic                 iss0_valid_o,
  output logic [IW-1:0]        iss0_instr_o,
  output logic                 iss1_valid_o,
  output logic [IW-1:0]        iss1_instr_o,
  output logic [NUM_UNITS-1:0] unit_go_o,
  output logic                 stall_o
);
  localparam int SA_LO = UNIT_W;
  localparam int SB_LO = UNIT_W + REG_W;
  localparam int DS_LO = UNIT_W + 2*REG_W;

  logic          head_v, next_v;
  logic [IW-1:0] head_i, next_i;
  logic          take_head, take_next;
  issue_e        issue_sel;
  logic [NUM_UNITS-1:0] go_now, unit_occ;

  disp_window #(.IW(IW)) u_window (
    .clk, .rst,
    .issue_sel    (issue_sel),
    .in_valid_i   (in_valid_i),
    .in_instr0_i  (in_instr0_i),
    .in_instr1_i  (in_instr1_i),
    .in_ready_o   (in_ready_o),
    .head_valid_o (head_v),
    .head_instr_o (head_i),
    .next_valid_o (next_v),
    .next_instr_o (next_i)
  );

  disp_select #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .REG_W(REG_W)) u_select (
    .head_v    (head_v),
    .head_unit (head_i[UNIT_W-1:0]),
    .head_dst  (head_i[DS_LO +: REG_W]),
    .next_v    (next_v),
    .next_unit (next_i[UNIT_W-1:0]),
    .next_srca (next_i[SA_LO +: REG_W]),
    .next_srcb (next_i[SB_LO +: REG_W]),
    .next_dst  (next_i[DS_LO +: REG_W]),
    .unit_busy (unit_occ),
    .take_head (take_head),
    .take_next (take_next)
  );

  assign issue_sel = take_next ? ISSUE_PAIR : (take_head ? ISSUE_OLDER : ISSUE_NONE);

  always_comb begin
    go_now = '0;
    if (take_head) go_now[head_i[UNIT_W-1:0]] = 1'b1;
    if (take_next) go_now[next_i[UNIT_W-1:0]] = 1'b1;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int UII = int'(UNIT_II[u*II_W +: II_W]);
    disp_interval #(.II(UII), .CW(II_W)) u_interval (
      .clk, .rst,
      .go_i       (go_now[u]),
      .ext_busy_i (unit_busy_i[u]),
      .busy_o     (unit_occ[u])
    );
    AST_BUSY_HONORED: assert property (@(posedge clk) disable iff (rst)
      unit_go_o[u] |-> !$past(unit_busy_i[u]));  // R8
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss0_valid_o <= 1'b0;
      iss1_valid_o <= 1'b0;
      iss0_instr_o <= '0;
      iss1_instr_o <= '0;
      unit_go_o    <= '0;
      stall_o      <= 1'b0;
    end else begin
      iss0_valid_o <= take_head;
      iss1_valid_o <= take_next;
      iss0_instr_o <= head_i;
      iss1_instr_o <= next_i;
      unit_go_o    <= go_now;
      stall_o      <= head_v && !take_head;
    end
  end

  AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (rst)
    iss1_valid_o |-> iss0_valid_o);  // R3
  AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (rst)
    $countones(unit_go_o) == (32'(iss0_valid_o) + 32'(iss1_valid_o)));  // R4
  AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (iss1_valid_o && iss0_instr_o[DS_LO +: REG_W] != '0) |->
      (iss1_instr_o[SA_LO +: REG_W] != iss0_instr_o[DS_LO +: REG_W] &&
       iss1_instr_o[SB_LO +: REG_W] != iss0_instr_o[DS_LO +: REG_W]));  // R5
  AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (iss1_valid_o && iss0_instr_o[DS_LO +: REG_W] != '0) |->
      (iss1_instr_o[DS_LO +: REG_W] != iss0_instr_o[DS_LO +: REG_W]));  // R6
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !iss0_valid_o);  // R10
endmodule

// File: tb/tb_dual_issue_dispatch.sv
`timescale 1ns/1ps
module tb_dual_issue_dispatch;
  localparam int NU = 4;
  localparam int IW = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]    in_valid = '0;
  logic [IW-1:0] in0 = '0, in1 = '0;
  logic [1:0]    in_ready;
  logic [NU-1:0] busy = '0;
  logic          iss0_v, iss1_v, stall;
  logic [IW-1:0] iss0_i, iss1_i;
  logic [NU-1:0] go;

  always #2 clk = ~clk;

  dual_issue_dispatch dut (
    .clk, .rst,
    .in_valid_i (in_valid), .in_instr0_i (in0), .in_instr1_i (in1),
    .in_ready_o (in_ready), .unit_busy_i (busy),
    .iss0_valid_o (iss0_v), .iss0_instr_o (iss0_i),
    .iss1_valid_o (iss1_v), .iss1_instr_o (iss1_i),
    .unit_go_o (go), .stall_o (stall)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  int ii_tb [NU] = '{1, 1, 2, 3};
  int q [16384];
  int head = 0, tail = 0;
  int cyc = 0;
  int last_go [NU] = '{-100, -100, -100, -100};
  int cyc_of [256];
  bit issued [256];
  logic [NU-1:0] busy_dec = '0;
  int tag_ctr = 0;

  function automatic logic [IW-1:0] mk(int u, int sa, int sb, int d, int t);
    return {8'(t), 5'(d), 5'(sb), 5'(sa), 2'(u)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic take(logic [IW-1:0] ins);
    int t = int'(ins[24:17]);
    int u = int'(ins[1:0]);
    chk(head != tail, "R11 issue from empty window", 1, 0);
    if (head != tail) begin
      chk(t == q[head], "R2 issue order tag", t, q[head]);
      head++;
    end
    chk(cyc - last_go[u] >= ii_tb[u], "R7 interval gap", cyc - last_go[u], ii_tb[u]);
    last_go[u] = cyc;
    chk(!busy_dec[u], "R8 busy unit issued", 1, 0);
    issued[t] = 1'b1;
    cyc_of[t] = cyc;
  endtask

  task automatic monitor();
    logic [NU-1:0] expgo = '0;
    if (iss1_v && !iss0_v) chk(0, "R3 younger alone", 1, 0);
    if (iss0_v) begin take(iss0_i); expgo[iss0_i[1:0]] = 1'b1; end
    if (iss1_v) begin
      take(iss1_i);
      expgo[iss1_i[1:0]] = 1'b1;
      chk(iss1_i[1:0] != iss0_i[1:0], "R4 pair on one unit", int'(iss1_i[1:0]), -1);
      chk(iss0_i[16:12] == 0 || (iss1_i[6:2] != iss0_i[16:12] && iss1_i[11:7] != iss0_i[16:12]),
          "R5 pair with RAW", int'(iss1_i[6:2]), int'(iss0_i[16:12]));
      chk(iss0_i[16:12] == 0 || iss1_i[16:12] != iss0_i[16:12],
          "R6 pair with WAW", int'(iss1_i[16:12]), int'(iss0_i[16:12]));
    end
    if (iss0_v) chk(go == expgo, "R4 unit strobes", int'(go), int'(expgo));
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic step();
    bit a0, a1;
    #0.5;
    a0 = in_valid[0] && in_ready[0];
    a1 = in_valid[0] && in_valid[1] && in_ready[1];
    if (a0) begin q[tail] = int'(in0[24:17]); issued[in0[24:17]] = 1'b0; tail++; end
    if (a1) begin q[tail] = int'(in1[24:17]); issued[in1[24:17]] = 1'b0; tail++; end
    tag_ctr = (tag_ctr + int'(a0) + int'(a1)) % 256;
    busy_dec = busy;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    monitor();
  endtask

  task automatic idle(int n);
    in_valid = '0;
    busy = '0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_pair(logic [IW-1:0] a, logic [IW-1:0] b);
    in0 = a; in1 = b; in_valid = 2'b11;
    step();
    in_valid = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int ta, tb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #0.5;
    // R1 reset state
    chk(!iss0_v && !iss1_v && go == 0 && !stall, "R1 outputs after reset", int'(go), 0);
    chk(in_ready == 2'b11, "R1 ready after reset", int'(in_ready), 3);
    @(negedge clk);
    idle(4);  // R11 empty window never issues (monitor flags any issue)

    // R12 dual issue with no conflict
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(0, 1, 2, 3, ta), mk(3, 4, 5, 6, tb));
    idle(4);
    chk(issued[ta] && issued[tb] && cyc_of[ta] == cyc_of[tb], "R12 pair same cycle",
        cyc_of[tb], cyc_of[ta]);

    // R4 / R9 same unit: older first, younger next cycle
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(1, 1, 2, 3, ta), mk(1, 4, 5, 6, tb));
    idle(4);
    chk(cyc_of[tb] == cyc_of[ta] + 1, "R4 R9 same unit split", cyc_of[tb], cyc_of[ta] + 1);

    // R5 RAW on source B
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(0, 1, 2, 3, ta), mk(1, 4, 3, 6, tb));
    idle(4);
    chk(cyc_of[tb] == cyc_of[ta] + 1, "R5 RAW split", cyc_of[tb], cyc_of[ta] + 1);

    // R5 zero destination is no hazard
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(0, 1, 2, 0, ta), mk(1, 0, 0, 6, tb));
    idle(4);
    chk(cyc_of[tb] == cyc_of[ta], "R5 zero dst pairs", cyc_of[tb], cyc_of[ta]);

    // R6 same destination
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(0, 1, 2, 7, ta), mk(1, 4, 5, 7, tb));
    idle(4);
    chk(cyc_of[tb] == cyc_of[ta] + 1, "R6 WAW split", cyc_of[tb], cyc_of[ta] + 1);

    // R7 interval of unit 3 is exactly honoured
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    send_pair(mk(3, 1, 2, 3, ta), mk(3, 4, 5, 6, tb));
    idle(6);
    chk(cyc_of[tb] == cyc_of[ta] + 3, "R7 unit 3 gap", cyc_of[tb] - cyc_of[ta], 3);

    // R10 stall: head blocked by an external busy unit
    busy = 4'b0100;
    ta = tag_ctr; tb = (tag_ctr + 1) % 256;
    in0 = mk(2, 1, 2, 3, ta); in1 = mk(0, 4, 5, 6, tb); in_valid = 2'b11;
    step();
    in_valid = '0;
    for (int i = 0; i < 3; i++) step();
    chk(stall == 1'b1, "R10 stall flag", int'(stall), 1);
    #0.3;
    chk(in_ready == 2'b00, "R10 full window not ready", int'(in_ready), 0);
    chk(!issued[ta] && !issued[tb], "R10 nothing issued", int'(issued[ta]), 0);
    busy = '0;
    step(); step();
    chk(issued[ta] && issued[tb] && cyc_of[ta] == cyc_of[tb], "R10 release pair",
        cyc_of[tb], cyc_of[ta]);
    idle(3);

    // R11 one free place: only lane 0 is accepted
    busy = 4'b0100;
    ta = tag_ctr;
    in0 = mk(2, 1, 2, 3, ta); in_valid = 2'b01;
    step();
    tb = tag_ctr;
    in0 = mk(0, 4, 5, 6, tb); in1 = mk(1, 7, 8, 9, (tb + 1) % 256); in_valid = 2'b11;
    #0.3;
    chk(in_ready == 2'b01, "R11 one place free", int'(in_ready), 1);
    step();
    in_valid = '0;
    busy = '0;
    step(); step(); step();
    chk(issued[ta] && issued[tb] && head == tail, "R11 only lane 0 taken", tail - head, 0);
    idle(3);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      int r = int'($urandom % 4);
      for (int u = 0; u < NU; u++) busy[u] = ($urandom % 8) == 0;
      in0 = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), tag_ctr);
      in1 = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
               (tag_ctr + 1) % 256);
      in_valid = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      step();
    end
    idle(20);
    chk(head == tail, "R2 all accepted issued", tail - head, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end
endmodule